// File: doc/BRIEF.md
# Center-Aligned PWM Timebase

This block is the timebase of a single PWM channel. A programmable prescaler and a power-of-two divider turn the system clock into a slower tick. The tick is produced as a clock-enable pulse, so the whole block runs in one clock domain. On each tick a 16-bit counter moves in one of two ways. In edge mode it counts down once per period. In center mode it counts up, turns round and counts back down. Comparing the count against a compare value gives a raw PWM waveform.

Software programs the block through a plain write strobe with an address and a data word. The period, compare and alignment settings are held in shadow registers and reach the running counter only at a period boundary, so a write made in the middle of a period never distorts the pulse in progress. Three sticky flags record period events, duty events and a selectable ADC trigger point. Each flag stays set until software writes a one to it.

Top module: `cpwm_timebase`

## Requirements
- R1: The divider select in control bits 8:6 divides the prescaled ticks by 2, 4, 8 or 16 for codes 0, 1, 2 and 3. Code 4, and any code above 4, divides by 1.
- R2: A value N in the prescaler register (address 1) gives one prescaled tick every N+1 clocks. The counter changes only on a tick.
- R3: In edge mode (control bit 1 = 0) the counter counts down from the period value P to 0 and reloads, so one period lasts P+1 ticks. pwm_out is high while the count is at or below the compare value.
- R4: In center mode (control bit 1 = 1) the counter runs up from 1 to P and then down to 0, so one period lasts 2P ticks. pwm_out is high while the count is at or below the compare value.
- R5: The period (address 2), compare (address 3) and alignment settings are copied into the running counter only on a tick at which the count is zero. A value written in the middle of a period first takes effect in the period that follows.
- R6: While the active period is 0 the counter holds at zero, pwm_out stays low and no flag is set.
- R7: flags[0] (period) is set on the tick at which the count is zero when control bit 2 is 0. When control bit 2 is 1 it is set on the tick at which the count equals the period.
- R8: flags[1] (duty) is set on a tick at which the count equals the compare value and the counting direction matches control bit 3 (0 = down, 1 = up). Edge mode always counts as down.
- R9: flags[2] (ADC trigger) is set by the point chosen in control bits 5:4: 0 = a rising edge of pwm_out, 1 = a falling edge, 2 = the tick at which the count equals the period, 3 = the tick at which the count is zero.
- R10: The flags are sticky. A write to address 4 clears each flag whose data bit is one. An event in the same cycle wins over the clear.
- R11: With the run bit (control bit 0) at 0, the prescaler, divider and counter are held at zero and pwm_out is low.
- R12: After reset, pwm_out is low and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 control, 1 prescaler, 2 period, 3 compare, 4 flag clear |
| wr_data | input | CNT_W (16) | Write data |
| pwm_out | output | 1 | Raw PWM waveform |
| flags | output | 3 | Sticky flags: bit 0 period, bit 1 duty, bit 2 ADC trigger |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, an 8-bit prescaler and the divider variant enabled. These defaults make every divider code reachable, including the divide-by-16 code and the codes that fall back to divide-by-1. Periods of 1 to 9 ticks with prescaler values of 0 and 2 keep each measurement window to a few hundred clocks. The windows still cover whole numbers of periods, so the measured high-time ratios, the gaps between pulses across a shadowed reload, and the conditions that set each flag can all be predicted exactly.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

   // register addresses
   localparam logic [2:0] ADDR_CTRL = 3'd0;
   localparam logic [2:0] ADDR_PSC  = 3'd1;
   localparam logic [2:0] ADDR_PER  = 3'd2;
   localparam logic [2:0] ADDR_CMP  = 3'd3;
   localparam logic [2:0] ADDR_CLR  = 3'd4;

   // flag positions
   localparam int NFLAG    = 3;
   localparam int FLG_PER  = 0;
   localparam int FLG_DUTY = 1;
   localparam int FLG_ADC  = 2;

   typedef enum logic [1:0] {
      TRIG_RISE = 2'd0,
      TRIG_FALL = 2'd1,
      TRIG_TOP  = 2'd2,
      TRIG_ZERO = 2'd3
   } trig_sel_e;

   // control word: div[8:6] trig[5:4] duty_up[3] per_top[2] center[1] run[0]
   typedef struct packed {
      logic [2:0] div;
      trig_sel_e  trig;
      logic       duty_up;
      logic       per_top;
      logic       center;
      logic       run;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

   // divider code -> log2 of the division ratio
   function automatic int div_shift(input logic [2:0] code);
      case (code)
         3'd0:    return 1;
         3'd1:    return 2;
         3'd2:    return 3;
         3'd3:    return 4;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/cpwm_tick_gen.sv
module cpwm_tick_gen
   import cpwm_pkg::*;
#(
   parameter int PSC_W       = 8,
   parameter int MAX_SHIFT   = 4,
   parameter bit HAS_DIVIDER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PSC_W-1:0] psc,
   input  logic [2:0]       div_code,
   output logic             tick
);

   initial begin
      p_shift_room_r1: assert (MAX_SHIFT >= 4)
         else $error("divider needs at least 4 stages");
   end

   logic [PSC_W-1:0] pre_cnt;
   logic             pre_tick;

   assign pre_tick = run && (pre_cnt == psc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pre_cnt <= '0;
      else if (!run || pre_tick) pre_cnt <= '0;
      else                       pre_cnt <= pre_cnt + PSC_W'(1);
   end

   generate
      if (HAS_DIVIDER) begin : g_div
         logic [MAX_SHIFT-1:0] div_cnt;
         logic [MAX_SHIFT-1:0] mask;
         int                   sh;

         always_comb begin
            sh = div_shift(div_code);
            for (int i = 0; i < MAX_SHIFT; i++) mask[i] = (i < sh);
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        div_cnt <= '0;
            else if (!run)     div_cnt <= '0;
            else if (pre_tick) div_cnt <= div_cnt + MAX_SHIFT'(1);
         end

         assign tick = pre_tick && ((div_cnt & mask) == mask);
      end else begin : g_nodiv
         assign tick = pre_tick;
      end
   endgenerate

   // after a tick the prescaler restarts, so a tick on the next clock needs psc == 0
   p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (!tick || psc == '0));

endmodule

// File: rtl/cpwm_counter.sv
module cpwm_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             center_sh,
   input  logic [CNT_W-1:0] per_sh,
   input  logic [CNT_W-1:0] cmp_sh,
   output logic             pwm_raw,
   output logic             at_zero,
   output logic             at_top,
   output logic             duty_up_hit,
   output logic             duty_dn_hit
);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] per_a;
   logic [CNT_W-1:0] cmp_a;
   logic             center_a;
   logic             dir_up;
   logic             live;
   logic             cmp_eq;
   logic             going_up;

   assign live     = run && (per_a != '0);
   assign cmp_eq   = tick && live && (cnt == cmp_a);
   assign going_up = center_a && dir_up;

   assign pwm_raw     = live && (cnt <= cmp_a);
   assign at_zero     = tick && live && (cnt == '0);
   assign at_top      = tick && live && (cnt == per_a);
   assign duty_up_hit = cmp_eq && going_up;
   assign duty_dn_hit = cmp_eq && !going_up;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         per_a    <= '0;
         cmp_a    <= '0;
         center_a <= 1'b0;
         dir_up   <= 1'b1;
      end else if (!run) begin
         cnt      <= '0;
         per_a    <= '0;
         cmp_a    <= '0;
         center_a <= 1'b0;
         dir_up   <= 1'b1;
      end else if (tick) begin
         if (cnt == '0) begin
            // period boundary: shadows become active
            per_a    <= per_sh;
            cmp_a    <= cmp_sh;
            center_a <= center_sh;
            dir_up   <= 1'b1;
            if (per_sh == '0)   cnt <= '0;
            else if (center_sh) cnt <= CNT_W'(1);
            else                cnt <= per_sh;
         end else if (going_up) begin
            if (cnt >= per_a) begin
               dir_up <= 1'b0;
               cnt    <= cnt - CNT_W'(1);
            end else begin
               cnt    <= cnt + CNT_W'(1);
            end
         end else begin
            cnt <= cnt - CNT_W'(1);
         end
      end
   end

   p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (per_a != '0) |-> (cnt <= per_a));

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(cnt));

   p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));

   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && center_a && cnt != '0) |=>
         (cnt == $past(cnt) + CNT_W'(1) || cnt == $past(cnt) - CNT_W'(1)));

   p_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (per_a == '0) |=> (cnt == '0 || $past(tick)));

endmodule

// File: rtl/cpwm_evt_flags.sv
module cpwm_evt_flags
   import cpwm_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             at_zero,
   input  logic             at_top,
   input  logic             duty_up_hit,
   input  logic             duty_dn_hit,
   input  logic             pwm_raw,
   input  logic             per_top_sel,
   input  logic             duty_up_sel,
   input  trig_sel_e        trig_sel,
   input  logic [NFLAG-1:0] clr,
   output logic [NFLAG-1:0] flags
);

   logic             pwm_prev;
   logic             rise;
   logic             fall;
   logic [NFLAG-1:0] set;

   assign rise = pwm_raw && !pwm_prev;
   assign fall = !pwm_raw && pwm_prev;

   always_comb begin
      set           = '0;
      set[FLG_PER]  = per_top_sel ? at_top : at_zero;
      set[FLG_DUTY] = duty_up_sel ? duty_up_hit : duty_dn_hit;
      case (trig_sel)
         TRIG_RISE: set[FLG_ADC] = rise;
         TRIG_FALL: set[FLG_ADC] = fall;
         TRIG_TOP:  set[FLG_ADC] = at_top;
         default:   set[FLG_ADC] = at_zero;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwm_prev <= 1'b0;
         flags    <= '0;
      end else begin
         pwm_prev <= pwm_raw;
         flags    <= (flags & ~clr) | set;
      end
   end

   p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags & $past(flags & ~clr)) == $past(flags & ~clr)));

endmodule

// File: rtl/cpwm_timebase.sv
module cpwm_timebase
   import cpwm_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PSC_W       = 8,
   parameter bit HAS_DIVIDER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic             pwm_out,
   output logic [NFLAG-1:0] flags
);

   initial begin
      p_word_fits_r5: assert (CNT_W >= CTRL_W && CNT_W >= PSC_W)
         else $error("write word too narrow for control or prescaler");
   end

   ctrl_t            ctrl_q;
   logic [PSC_W-1:0] psc_q;
   logic [CNT_W-1:0] per_sh;
   logic [CNT_W-1:0] cmp_sh;
   logic [NFLAG-1:0] clr;
   logic             tick;
   logic             at_zero, at_top, duty_up_hit, duty_dn_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         psc_q  <= '0;
         per_sh <= '0;
         cmp_sh <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            ADDR_CTRL: ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
            ADDR_PSC:  psc_q  <= wr_data[PSC_W-1:0];
            ADDR_PER:  per_sh <= wr_data;
            ADDR_CMP:  cmp_sh <= wr_data;
            default:   ;
         endcase
      end
   end

   assign clr = (wr_en && wr_addr == ADDR_CLR) ? wr_data[NFLAG-1:0] : '0;

   cpwm_tick_gen #(
      .PSC_W      (PSC_W),
      .MAX_SHIFT  (4),
      .HAS_DIVIDER(HAS_DIVIDER)
   ) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctrl_q.run),
      .psc     (psc_q),
      .div_code(ctrl_q.div),
      .tick    (tick)
   );

   cpwm_counter #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (ctrl_q.run),
      .tick       (tick),
      .center_sh  (ctrl_q.center),
      .per_sh     (per_sh),
      .cmp_sh     (cmp_sh),
      .pwm_raw    (pwm_out),
      .at_zero    (at_zero),
      .at_top     (at_top),
      .duty_up_hit(duty_up_hit),
      .duty_dn_hit(duty_dn_hit)
   );

   cpwm_evt_flags u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .at_zero    (at_zero),
      .at_top     (at_top),
      .duty_up_hit(duty_up_hit),
      .duty_dn_hit(duty_dn_hit),
      .pwm_raw    (pwm_out),
      .per_top_sel(ctrl_q.per_top),
      .duty_up_sel(ctrl_q.duty_up),
      .trig_sel   (ctrl_q.trig),
      .clr        (clr),
      .flags      (flags)
   );

   p_idle_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.run && !(wr_en && wr_addr == ADDR_CTRL)) |=> !pwm_out);

endmodule

// File: tb/cpwm_timebase_tb.sv
module cpwm_timebase_tb;

   localparam int CLK_PERIOD = 10;
   localparam int TIMEOUT    = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        pwm_out;
   logic [2:0]  flags;

   int total = 0;
   int fails = 0;
   int cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   cpwm_timebase u_dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .pwm_out(pwm_out),
      .flags  (flags)
   );

   function automatic logic [15:0] mk(bit run, bit ctr, bit pt, bit du,
                                      logic [1:0] trig, logic [2:0] dv);
      return {7'b0, dv, trig, du, pt, ctr, run};
   endfunction

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic high_count(int n, output int h);
      h = 0;
      repeat (n) begin
         @(negedge clk);
         if (pwm_out) h++;
      end
   endtask

   task automatic wait_rise(output int t);
      logic prev;
      prev = pwm_out;
      forever begin
         @(negedge clk);
         if (pwm_out && !prev) begin
            t = cyc;
            break;
         end
         prev = pwm_out;
      end
   endtask

   task automatic setup(logic [7:0] psc, int per, int cmp);
      wr(3'd0, 16'h0);
      wr(3'd1, {8'h0, psc});
      wr(3'd2, 16'(per));
      wr(3'd3, 16'(cmp));
      wr(3'd4, 16'h7);
   endtask

   task automatic t_reset;
      chk("R12 pwm_out after reset", int'(pwm_out), 0);
      chk("R12 flags after reset", int'(flags), 0);
   endtask

   task automatic t_edge;
      int h;
      setup(8'd0, 4, 1);
      wr(3'd0, mk(1, 0, 0, 0, 2'd3, 3'd4));
      idle(20);
      high_count(50, h);
      chk("R3 edge high time P=4 C=1", h, 20);
   endtask

   task automatic t_center;
      int h;
      setup(8'd0, 4, 1);
      wr(3'd0, mk(1, 1, 0, 0, 2'd3, 3'd4));
      idle(30);
      high_count(80, h);
      chk("R4 center high time P=4 C=1", h, 30);
   endtask

   task automatic t_presc;
      int h;
      setup(8'd2, 4, 1);
      wr(3'd0, mk(1, 0, 0, 0, 2'd3, 3'd4));
      idle(60);
      high_count(150, h);
      chk("R2 prescaler 2 high time", h, 60);
   endtask

   task automatic t_div;
      int h;
      setup(8'd0, 4, 1);
      wr(3'd0, mk(1, 0, 0, 0, 2'd3, 3'd0));
      idle(40);
      high_count(100, h);
      chk("R1 divider code 0 (div 2)", h, 40);
      setup(8'd0, 1, 0);
      wr(3'd0, mk(1, 0, 0, 0, 2'd3, 3'd3));
      idle(128);
      high_count(320, h);
      chk("R1 divider code 3 (div 16)", h, 160);
      setup(8'd0, 4, 1);
      wr(3'd0, mk(1, 0, 0, 0, 2'd3, 3'd7));
      idle(20);
      high_count(50, h);
      chk("R1 divider code 7 (div 1)", h, 20);
   endtask

   task automatic t_shadow;
      int t1, t2, t3;
      setup(8'd0, 9, 0);
      wr(3'd0, mk(1, 0, 0, 0, 2'd3, 3'd4));
      wait_rise(t1);
      idle(2);
      wr(3'd2, 16'd4);
      wait_rise(t2);
      wait_rise(t3);
      chk("R5 old period finishes after mid-period write", t2 - t1, 10);
      chk("R5 new period used from next boundary", t3 - t2, 5);
   endtask

   task automatic t_stop;
      int h;
      setup(8'd0, 4, 1);
      wr(3'd0, mk(1, 0, 0, 0, 2'd3, 3'd4));
      idle(20);
      wr(3'd2, 16'd0);
      idle(20);
      wr(3'd4, 16'h7);
      high_count(40, h);
      chk("R6 period 0 keeps output low", h, 0);
      chk("R6 period 0 sets no flag", int'(flags), 0);
   endtask

   task automatic t_flags;
      setup(8'd0, 4, 1);
      wr(3'd0, mk(1, 0, 0, 0, 2'd3, 3'd4));
      idle(30);
      wr(3'd0, mk(0, 0, 0, 0, 2'd3, 3'd4));
      idle(2);
      chk("R7 R8 R9 zero-point flags all set", int'(flags), 7);
      wr(3'd4, 16'h1);
      chk("R10 clear only period flag", int'(flags), 6);
      wr(3'd4, 16'h6);
      chk("R10 clear remaining flags", int'(flags), 0);

      wr(3'd0, mk(1, 0, 1, 1, 2'd2, 3'd4));
      idle(30);
      wr(3'd0, mk(0, 0, 1, 1, 2'd2, 3'd4));
      idle(2);
      chk("R8 edge mode never matches up-count; R7 R9 top point", int'(flags), 5);
      wr(3'd4, 16'h7);

      wr(3'd0, mk(1, 1, 0, 1, 2'd3, 3'd4));
      idle(30);
      wr(3'd0, mk(0, 1, 0, 1, 2'd3, 3'd4));
      idle(2);
      chk("R8 center mode up-count duty match", int'(flags[1]), 1);
      wr(3'd4, 16'h7);

      setup(8'd0, 3, 3);
      wr(3'd0, mk(1, 0, 0, 0, 2'd0, 3'd4));
      idle(20);
      chk("R9 rising trigger at start", int'(flags[2]), 1);
      wr(3'd4, 16'h4);
      idle(20);
      chk("R9 steady high gives no new rise", int'(flags[2]), 0);
      wr(3'd0, mk(1, 0, 0, 0, 2'd1, 3'd4));
      idle(20);
      chk("R9 steady high gives no fall", int'(flags[2]), 0);
      wr(3'd0, mk(1, 0, 0, 0, 2'd2, 3'd4));
      idle(10);
      chk("R9 top-point trigger", int'(flags[2]), 1);

      setup(8'd0, 4, 1);
      wr(3'd0, mk(1, 0, 0, 0, 2'd1, 3'd4));
      idle(20);
      chk("R9 falling trigger", int'(flags[2]), 1);
      wr(3'd0, 16'h0);
      wr(3'd4, 16'h7);
   endtask

   task automatic t_idle;
      int h;
      setup(8'd0, 4, 4);
      high_count(30, h);
      chk("R11 run=0 keeps output low", h, 0);
      wr(3'd0, mk(1, 0, 0, 0, 2'd3, 3'd4));
      idle(5);
      high_count(30, h);
      chk("R3 compare equal to period keeps output high", h, 30);
      wr(3'd0, 16'h0);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset;
      t_edge;
      t_center;
      t_presc;
      t_div;
      t_shadow;
      t_stop;
      t_flags;
      t_idle;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (TIMEOUT) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", TIMEOUT, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule